// File: doc/BRIEF.md
# Windowed Table Reducer for Binary Polynomials

This block takes a binary polynomial of `2·FIELD_WORDS` words and reduces it modulo a field polynomial f(x) = x^m + g(x). The tail g(x) may be dense. Nothing assumes a trinomial or a pentanomial. The reduction works on 8-bit windows from the most significant end downward. For each window with a non-zero value, it looks up one precomputed multiple of g(x) and XORs it in at a word-aligned position. No bit shifting happens per window.

Before any reduction, the user loads a field on the field-load port: a degree `fld_m` with (FIELD_WORDS-1)·WORD_W < m ≤ FIELD_WORDS·WORD_W, and a tail `fld_fp` whose degree is below m. A fill engine then builds the table in a synchronous RAM, once per field. The RAM has (WORD_W/8)·255 entries of FIELD_WORDS+1 words each. The entry at {j, t} equals t(x)·x^(8j)·x^W·g(x)/x^r, where r = m − (FIELD_WORDS−1)·WORD_W. It is built from a running single-bit entry that moves up one bit at each power-of-two index. Every other index is formed as the XOR of that running entry and the entry at t with its top bit removed.

After the table is filled, `start` launches a reduction. The reducer has four states:
- IDLE: goes to SCAN on an accepted start.
- SCAN: goes to APPLY when the masked window is non-zero. When the window is zero it steps down one window, or goes to DONE once the lowest window has been checked.
- APPLY: XORs the window and its table entry into the operand, then returns to SCAN on the same window.
- DONE: pulses `done` and returns to IDLE.

The fill engine has three states:
- IDLE: goes to READ on a field load.
- READ: issues the read of the partial entry, then goes to WRITE.
- WRITE: stores the entry, then goes back to READ, or to IDLE after the last entry.

In full mode, the windows that are scanned reach down to the one that holds bit m, and window bits below m are masked off. In partial mode the scan stops at bit FIELD_WORDS·WORD_W.

Top module: `gf2_win_reducer`

## Requirements
- R1: After reset `fld_ready` and `done` are low.
- R2: `start` has no effect while `fld_ready` is low, either before any field is loaded or while a table fill runs; `done` never rises then.
- R3: The table fill takes two cycles per entry, so `fld_ready` rises between 2·E and 2·E+2 cycles after the load edge, with E = (WORD_W/8)·255.
- R4: In full mode `res` equals `op_in` mod (x^m + g), and no bit at position m or above is set.
- R5: In partial mode `res` is congruent to `op_in` modulo the field polynomial and fits in FIELD_WORDS words. An operand with no bit at or above FIELD_WORDS·WORD_W comes back unchanged.
- R6: A window whose masked value is zero costs exactly one cycle. When every scanned window is zero, `done` appears NWIN − klow + 1 cycles after the start edge, where NWIN = 2·FIELD_WORDS·WORD_W/8, klow = m>>3 in full mode, and klow = FIELD_WORDS·WORD_W/8 in partial mode.
- R7: When m is not a multiple of 8, the bits of the straddling window that lie below m are never reduced, and table words that fall below bit 0 are zero.
- R8: `done` is a one-cycle pulse, and `res` holds its value afterwards.
- R9: A new field load, accepted only in IDLE, drops `fld_ready` at once. Later results use the new field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fld_load | input | 1 | Load a new field and start the table fill |
| fld_m | input | $clog2(FIELD_WORDS·WORD_W+1) | Degree m of the field polynomial |
| fld_fp | input | FIELD_WORDS·WORD_W | Tail g(x), degree below m |
| fld_ready | output | 1 | Table is valid for the loaded field |
| start | input | 1 | Begin a reduction of `op_in` |
| partial | input | 1 | 1: stop at degree below FIELD_WORDS·WORD_W |
| op_in | input | 2·FIELD_WORDS·WORD_W | Operand to reduce |
| done | output | 1 | One-cycle completion pulse |
| res | output | FIELD_WORDS·WORD_W | Reduced result |

## Verification
The bench covers the following corner cases:
- Degrees that are not multiples of 8 (17, 19, 31). A design that reduced the whole straddling window would corrupt bits just below m.
- A degree equal to the full field width, where the top word holds nothing to reduce.
- Dense tails. These make a single lookup leave lower bits set in the same window, so a design that moved on after one XOR would leave bits at or above m.
- All-zero windows, which expose an off-by-one in the scan limit through the exact latency.
- Partial mode, which a design that ignored the flag would return fully reduced or not reduced at all.
- Field reloads, where stale table contents would show up as wrong results.

// File: rtl/gfwr_pkg.sv
package gfwr_pkg;

    typedef enum logic [1:0] {FL_IDLE, FL_READ, FL_WRITE} fill_state_t;

    typedef enum logic [1:0] {RD_IDLE, RD_SCAN, RD_APPLY, RD_DONE} red_state_t;

    function automatic logic is_pow2(input logic [7:0] t);
        return (t != 8'd0) && ((t & (t - 8'd1)) == 8'd0);
    endfunction

    function automatic logic [7:0] top_bit(input logic [7:0] t);
        logic [7:0] r;
        r = '0;
        for (int b = 0; b < 8; b++) begin
            if (t[b]) r = 8'b1 << b;
        end
        return r;
    endfunction

endpackage

// File: rtl/gfwr_table.sv
module gfwr_table #(
    parameter int AW = 9,
    parameter int DW = 48
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/gfwr_fill.sv
module gfwr_fill
    import gfwr_pkg::*;
#(
    parameter int W  = 16,
    parameter int S  = 2,
    parameter int JB = 1,
    parameter int MW = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [MW-1:0]        m,
    input  logic [S*W-1:0]       fp,
    output logic                 busy,
    output logic                 fin,
    output logic                 we,
    output logic [JB+7:0]        waddr,
    output logic [(S+1)*W-1:0]   wdata,
    output logic [JB+7:0]        raddr,
    input  logic [(S+1)*W-1:0]   rdata
);
    localparam int NB = W / 8;
    localparam int EW = (S + 1) * W;

    fill_state_t   state, nxt;
    logic [JB-1:0] j_q;
    logic [7:0]    t_q, t_nx;
    logic [EW-1:0] pwr_q;
    logic          last;
    int            sh0;

    assign last = (j_q == JB'(NB - 1)) && (t_q == 8'd255);
    assign t_nx = (t_q == 8'd255) ? 8'd1 : t_q + 8'd1;
    assign sh0  = W - (int'(m) - (S - 1) * W);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= FL_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            FL_IDLE:  nxt = FL_IDLE;
            FL_READ:  nxt = FL_WRITE;
            FL_WRITE: nxt = last ? FL_IDLE : FL_READ;
            default:  nxt = FL_IDLE;
        endcase
        if (load) nxt = FL_READ;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            j_q   <= '0;
            t_q   <= '0;
            pwr_q <= '0;
        end else if (load) begin
            j_q   <= '0;
            t_q   <= 8'd1;
            pwr_q <= EW'(fp) << sh0;
        end else if (state == FL_WRITE && !last) begin
            t_q <= t_nx;
            if (t_q == 8'd255) j_q <= j_q + JB'(1);
            if (is_pow2(t_nx)) pwr_q <= pwr_q << 1;
        end
    end

    always_comb begin
        busy  = (state != FL_IDLE);
        we    = (state == FL_WRITE);
        fin   = we && last;
        waddr = {j_q, t_q};
        raddr = {j_q, t_q ^ top_bit(t_q)};
        wdata = is_pow2(t_q) ? pwr_q : (pwr_q ^ rdata);
    end

    // R3: index zero is never written by the fill
    p_write_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (t_q != 8'd0));

    // R3: the write phase always follows a read phase
    p_read_before_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FL_WRITE) |-> $past(state) == FL_READ);
endmodule

// File: rtl/gf2_win_reducer.sv
module gf2_win_reducer
    import gfwr_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int FIELD_WORDS = 2
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          fld_load,
    input  logic [$clog2(FIELD_WORDS*WORD_W+1)-1:0]       fld_m,
    input  logic [FIELD_WORDS*WORD_W-1:0]                 fld_fp,
    output logic                                          fld_ready,
    input  logic                                          start,
    input  logic                                          partial,
    input  logic [2*FIELD_WORDS*WORD_W-1:0]               op_in,
    output logic                                          done,
    output logic [FIELD_WORDS*WORD_W-1:0]                 res
);
    localparam int W    = WORD_W;
    localparam int S    = FIELD_WORDS;
    localparam int SW   = S * W;
    localparam int CW   = 2 * SW;
    localparam int EW   = SW + W;
    localparam int XW   = CW + W;
    localparam int NB   = W / 8;
    localparam int NWIN = CW / 8;
    localparam int KW   = $clog2(NWIN);
    localparam int JB   = (NB > 1) ? $clog2(NB) : 1;
    localparam int AW   = JB + 8;
    localparam int MW   = $clog2(SW + 1);

    red_state_t    state, nxt;
    logic [MW-1:0] m_q;
    logic [CW-1:0] c_q;
    logic [KW-1:0] k_q, klow;
    logic          part_q;
    logic          load_ok, start_ok;

    logic          fl_busy, fl_fin, fl_we;
    logic [AW-1:0] fl_waddr, fl_raddr, rd_raddr, t_raddr;
    logic [EW-1:0] fl_wdata, t_rdata;

    logic [7:0]    win, mask, val;
    logic [JB-1:0] jsel;
    logic [XW-1:0] upd;
    int            wi;

    assign load_ok  = fld_load && (state == RD_IDLE);
    assign start_ok = start && fld_ready && !fld_load && (state == RD_IDLE);

    gfwr_fill #(.W(W), .S(S), .JB(JB), .MW(MW)) u_fill (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_ok),
        .m     (fld_m),
        .fp    (fld_fp),
        .busy  (fl_busy),
        .fin   (fl_fin),
        .we    (fl_we),
        .waddr (fl_waddr),
        .wdata (fl_wdata),
        .raddr (fl_raddr),
        .rdata (t_rdata)
    );

    assign t_raddr = fl_busy ? fl_raddr : rd_raddr;

    gfwr_table #(.AW(AW), .DW(EW)) u_table (
        .clk   (clk),
        .we    (fl_we),
        .waddr (fl_waddr),
        .wdata (fl_wdata),
        .raddr (t_raddr),
        .rdata (t_rdata)
    );

    // window selection and masking below bit m
    always_comb begin
        win = c_q[{k_q, 3'b000} +: 8];
        for (int b = 0; b < 8; b++) begin
            mask[b] = (int'(k_q) * 8 + b) >= int'(m_q);
        end
        val  = win & mask;
        jsel = JB'(int'(k_q) % NB);
        wi   = int'(k_q) / NB;
        rd_raddr = {jsel, val};
        klow = part_q ? KW'(SW / 8) : KW'(m_q >> 3);
        upd  = {c_q, {W{1'b0}}}
             ^ (XW'(t_rdata) << ((wi - (S - 1)) * W))
             ^ (XW'(val) << (int'(k_q) * 8 + W));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RD_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RD_IDLE:  nxt = start_ok ? RD_SCAN : RD_IDLE;
            RD_SCAN:  nxt = (val != 8'd0) ? RD_APPLY
                          : (k_q == klow) ? RD_DONE : RD_SCAN;
            RD_APPLY: nxt = RD_SCAN;
            RD_DONE:  nxt = RD_IDLE;
            default:  nxt = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q       <= '0;
            fld_ready <= 1'b0;
            c_q       <= '0;
            k_q       <= '0;
            part_q    <= 1'b0;
        end else begin
            if (load_ok) begin
                m_q       <= fld_m;
                fld_ready <= 1'b0;
            end else if (fl_fin) begin
                fld_ready <= 1'b1;
            end
            if (start_ok) begin
                c_q    <= op_in;
                k_q    <= KW'(NWIN - 1);
                part_q <= partial;
            end else if (state == RD_SCAN && val == 8'd0 && k_q != klow) begin
                k_q <= k_q - KW'(1);
            end else if (state == RD_APPLY) begin
                c_q <= upd[XW-1:W];
            end
        end
    end

    always_comb begin
        done = (state == RD_DONE);
        res  = c_q[SW-1:0];
    end

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: no completion without a valid table
    p_done_needs_table_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> fld_ready);

    // R3: the table never reads as valid while it is being filled
    p_fill_unready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fl_busy |-> !fld_ready);

    // R4: full mode leaves nothing at or above bit m
    p_full_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !part_q) |-> ((res >> m_q) == '0));

    // R6: each lookup strictly lowers the value of the window in progress
    p_window_shrinks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_APPLY) |=> (val < $past(val)));

    // R7: table words that land below bit 0 carry nothing
    p_drop_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_APPLY) |-> (upd[W-1:0] == '0));
endmodule

// File: tb/tb_gf2_win_reducer.sv
module tb_gf2_win_reducer;
    localparam int W       = 16;
    localparam int S       = 2;
    localparam int NB      = W / 8;
    localparam int NWIN    = 2 * S * W / 8;
    localparam int ENTRIES = NB * 255;

    typedef struct packed {
        logic [5:0]  m;
        logic [31:0] fp;
        logic [63:0] op;
        logic        part;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{6'd31, 32'h0000_0009, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
        '{6'd31, 32'h0000_0009, 64'h8000_0000_0000_0000, 1'b0},
        '{6'd31, 32'h0000_0009, 64'h1234_5678_9ABC_DEF0, 1'b1},
        '{6'd19, 32'h0005_A5A7, 64'hDEAD_BEEF_0BAD_F00D, 1'b0},
        '{6'd19, 32'h0005_A5A7, 64'h0000_0000_FFF8_0000, 1'b0},
        '{6'd19, 32'h0005_A5A7, 64'hFFFF_0000_0000_0001, 1'b1},
        '{6'd32, 32'h8DF3_1A27, 64'hCAFE_F00D_1357_9BDF, 1'b0},
        '{6'd17, 32'h0001_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
        '{6'd24, 32'h0000_001B, 64'h0123_4567_89AB_CDEF, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n, fld_load, start, partial, fld_ready, done;
    logic [5:0]  fld_m;
    logic [31:0] fld_fp, res;
    logic [63:0] op_in;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    gf2_win_reducer #(.WORD_W(W), .FIELD_WORDS(S)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fld_load  (fld_load),
        .fld_m     (fld_m),
        .fld_fp    (fld_fp),
        .fld_ready (fld_ready),
        .start     (start),
        .partial   (partial),
        .op_in     (op_in),
        .done      (done),
        .res       (res)
    );

    function automatic logic [63:0] ref_mod(input logic [63:0] v, input int m,
                                            input logic [31:0] fp);
        logic [64:0] f;
        f = {33'b0, fp} | (65'b1 << m);
        for (int b = 63; b >= 0; b--) begin
            if (b >= m && v[b]) v = v ^ 64'(f << (b - m));
        end
        return v;
    endfunction

    task automatic chk(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_field(input int m, input logic [31:0] fp);
        int   cnt;
        logic saw_done;
        @(negedge clk);
        fld_m    = 6'(m);
        fld_fp   = fp;
        fld_load = 1'b1;
        @(negedge clk);
        fld_load = 1'b0;
        cnt      = 1;
        saw_done = 1'b0;
        chk(fld_ready == 1'b0, "R9 ready drops on load", 64'(fld_ready), 64'd0);
        while (!fld_ready && cnt < 5000) begin
            start = (cnt == 10);
            @(negedge clk);
            cnt++;
            if (done) saw_done = 1'b1;
        end
        start = 1'b0;
        chk(cnt >= 2 * ENTRIES && cnt <= 2 * ENTRIES + 2, "R3 fill duration",
            64'(cnt), 64'(2 * ENTRIES + 1));
        chk(!saw_done, "R2 start ignored during fill", 64'(saw_done), 64'd0);
    endtask

    task automatic run_op(input logic [63:0] op, input logic part,
                          output logic [31:0] r, output int cyc);
        @(negedge clk);
        op_in   = op;
        partial = part;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc   = 1;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        r = res;
        @(negedge clk);
        chk(!done && res == r, "R8 done pulse and held result", {31'b0, done, res}, {32'b0, r});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int          cyc;
        int          cur_m;
        logic [31:0] cur_fp;
        logic        seen;

        rst_n = 1'b0; fld_load = 1'b0; start = 1'b0; partial = 1'b0;
        fld_m = '0; fld_fp = '0; op_in = '0;
        repeat (3) @(negedge clk);
        chk(fld_ready == 1'b0 && done == 1'b0, "R1 reset outputs",
            {fld_ready, done}, 64'd0);
        rst_n = 1'b1;

        // R2: start with no field loaded
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen  = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        chk(!seen, "R2 start ignored before load", 64'(seen), 64'd0);

        cur_m  = -1;
        cur_fp = '0;
        foreach (VECS[i]) begin
            if (int'(VECS[i].m) != cur_m || VECS[i].fp != cur_fp) begin
                load_field(int'(VECS[i].m), VECS[i].fp);
                cur_m  = int'(VECS[i].m);
                cur_fp = VECS[i].fp;
            end
            run_op(VECS[i].op, VECS[i].part, r, cyc);
            if (VECS[i].part) begin
                chk(ref_mod(64'(r), cur_m, cur_fp) == ref_mod(VECS[i].op, cur_m, cur_fp),
                    "R5 partial congruence", 64'(r), ref_mod(VECS[i].op, cur_m, cur_fp));
            end else begin
                chk(64'(r) == ref_mod(VECS[i].op, cur_m, cur_fp), "R4 full reduction",
                    64'(r), ref_mod(VECS[i].op, cur_m, cur_fp));
            end
        end

        // R6 and R5: zero windows cost one cycle each, short operand passes through
        load_field(31, 32'h0000_0009);
        run_op(64'h0000_0000_7FFF_FFFF, 1'b0, r, cyc);
        chk(r == 32'h7FFF_FFFF, "R6 unchanged below m", 64'(r), 64'h7FFF_FFFF);
        chk(cyc == NWIN - (31 >> 3) + 1, "R6 full-mode zero-window latency",
            64'(cyc), 64'(NWIN - (31 >> 3) + 1));
        run_op(64'h0000_0000_FFFF_FFFF, 1'b1, r, cyc);
        chk(r == 32'hFFFF_FFFF, "R5 partial passthrough", 64'(r), 64'hFFFF_FFFF);
        chk(cyc == NWIN - (S * W / 8) + 1, "R6 partial-mode zero-window latency",
            64'(cyc), 64'(NWIN - (S * W / 8) + 1));

        // R7: window straddling m=19 keeps its low bits
        load_field(19, 32'h0005_A5A7);
        run_op(64'h0000_0000_0007_ABCD, 1'b0, r, cyc);
        chk(r == 32'h0007_ABCD, "R7 straddling window untouched", 64'(r), 64'h0007_ABCD);
        run_op(64'h0000_0000_000F_ABCD, 1'b0, r, cyc);
        chk(64'(r) == ref_mod(64'h000F_ABCD, 19, 32'h0005_A5A7), "R7 bit m in straddling window",
            64'(r), ref_mod(64'h000F_ABCD, 19, 32'h0005_A5A7));

        // R9: reload replaces the table
        load_field(24, 32'h0000_001B);
        run_op(64'hFEDC_BA98_7654_3210, 1'b0, r, cyc);
        chk(64'(r) == ref_mod(64'hFEDC_BA98_7654_3210, 24, 32'h0000_001B), "R9 new field used",
            64'(r), ref_mod(64'hFEDC_BA98_7654_3210, 24, 32'h0000_001B));

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule